// File: doc/BRIEF.md
# Masked Sequential Connection Table Search

This block decides whether an incoming cell belongs to an open connection. It keeps a small table of connection identifiers. Each entry holds a 24-bit identifier and a 24-bit mask of the same width, and a mask bit of 1 makes that identifier bit a don't-care. When a header is offered, the block captures the identifier. An address counter then walks the table one entry per clock and compares each entry under its mask. The walk stops at the first accepted entry and reports its address as the connection number. If no entry is accepted, the walk runs to the last address and reports a miss.

An entry with every mask bit set is retired, and the walk steps over it. When the full identifier of an entry does not match, the entry can still accept the cell through its upper path byte alone, as a fallback. Address 0 is reserved for the idle-cell identifier, and a full hit there also raises an idle flag. A bypass input turns the search off: the accepted flag then follows an external tag. Table writes arrive on a separate port. They are held back while a search runs, so that a walk in progress always sees a stable table.

Top module: `conn_table_search`

## Requirements
- R1: A search starts only on a clock edge where the block is idle and `header_ok`, `id_avail` and NOT `bypass` are all 1. `busy` is 1 from the next cycle. Any other input combination leaves `busy` at 0 and the result flags unchanged.
- R2: Entry bit l is compared as (cell bit l XOR stored bit l) AND NOT mask bit l. The entry fully matches when all 24 of these terms are 0, so a mask bit of 1 ignores that bit position.
- R3: Entries are visited in rising address order starting at 0. The first accepted entry ends the search with `conn_valid`=1, `conn_invalid`=0 and `conn_id` equal to its address.
- R4: The path byte is identifier bits [23:16]. An entry whose full compare fails is still accepted when its masked compare over bits [23:16] alone is zero and its mask bits [23:16] are not all 1.
- R5: An entry whose 24 mask bits are all 1 is never accepted, and the search moves on to the next address.
- R6: If address 15 (ENTRIES-1) is examined without an accepted entry, the search ends with `conn_invalid`=1 and `conn_valid`=0. The two flags are never 1 together.
- R7: `idle_cell` is 1 exactly when a search ended on a full match at address 0. It is only ever 1 together with `conn_valid`=1 and `conn_id`=0.
- R8: While idle with `bypass`=1, `conn_valid` takes the value of `ext_tag` one cycle later. In that case `conn_invalid` and `idle_cell` are 0 and no search runs.
- R9: A search that accepts address k keeps `busy` high for k+1 cycles, and a miss keeps it high for ENTRIES cycles. The result flags are 0 while `busy` is 1. They hold their values from the end of a search until the next search start or bypass cycle.
- R10: A write request (`upd_en` with address, value and mask) is held in a pending register and enters the table on the first edge at which `busy` is 0. A search in progress never sees it. A new request made while one is still pending replaces it.
- R11: After reset every entry holds the idle identifier (default 0) with mask 0, `busy` is 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| header_ok | input | 1 | Header passed error check |
| id_avail | input | 1 | New identifier offered on cell_id |
| bypass | input | 1 | Skip search, pass ext_tag through |
| ext_tag | input | 1 | External acceptance tag used in bypass |
| cell_id | input | 24 | Identifier of the offered cell |
| upd_en | input | 1 | Table write request |
| upd_addr | input | 4 | Table address to write |
| upd_value | input | 24 | Identifier to store |
| upd_mask | input | 24 | Don't-care mask to store |
| busy | output | 1 | Search in progress |
| conn_valid | output | 1 | Cell accepted (or ext_tag in bypass) |
| conn_invalid | output | 1 | Search ended without acceptance |
| idle_cell | output | 1 | Full match at address 0 |
| conn_id | output | 4 | Address of the accepting entry |

## Verification
The search is run against six kinds of offered identifier. The first is the idle pattern, which must stop at address 0 and raise the idle flag. The second is an identifier absent from a freshly reset table, which must walk all sixteen entries. The third is an exact copy of a stored entry, and its `busy` length shows the address reached. The fourth differs only in masked bits and the fifth only in unmasked bits; together they separate the mask from a plain equality test. The sixth shares only the path byte with an earlier entry while matching a later entry in full, which shows that the fallback and the address order are both honoured. Further cases cover a retired entry holding a copy of the offered identifier, a write issued in the middle of a walk, the gating of the start condition, and bypass with both tag values.

// File: rtl/cts_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, table entry layout and engine state encoding
// for the masked connection table search.
package cts_pkg;
    localparam int ID_W  = 24;   // full connection identifier width
    localparam int VPI_W = 8;    // path byte at the top of the identifier

    // One table entry: stored identifier plus don't-care mask (1 = ignore).
    typedef struct packed {
        logic [ID_W-1:0] value;
        logic [ID_W-1:0] mask;
    } entry_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SEARCH = 1'b1
    } state_t;
endpackage

// File: rtl/cts_table.sv
`timescale 1ns/1ps
// Module: cts_table
// Register-based entry storage with one write port and one asynchronous
// read port. Every entry resets to IDLE_VALUE with a zero mask.
// Assumes ENTRIES is a power of two so the address covers it exactly.
module cts_table #(
    parameter int                    ENTRIES    = 16,
    parameter logic [cts_pkg::ID_W-1:0] IDLE_VALUE = '0,
    localparam int                   AW         = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  cts_pkg::entry_t     wr_entry,
    input  logic [AW-1:0]       rd_addr,
    output cts_pkg::entry_t     rd_entry
);
    import cts_pkg::*;

    entry_t mem [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        // Holds one entry; loads on a write aimed at this address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[e].value <= IDLE_VALUE;
                mem[e].mask  <= '0;
            end else if (wr_en && (wr_addr == AW'(e))) begin
                mem[e] <= wr_entry;
            end
        end
    end

    // Presents the entry addressed by the search counter.
    always_comb rd_entry = mem[rd_addr];
endmodule

// File: rtl/cts_update.sv
`timescale 1ns/1ps
// Module: cts_update
// Holds one table write request and releases it only while the search
// engine is idle, so a walk never sees the table change under it.
// Assumes a newer request may overwrite an older one still pending.
module cts_update #(
    parameter int  ENTRIES = 16,
    localparam int AW      = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_en,
    input  logic [AW-1:0]       upd_addr,
    input  logic [cts_pkg::ID_W-1:0] upd_value,
    input  logic [cts_pkg::ID_W-1:0] upd_mask,
    input  logic                engine_busy,
    output logic                wr_en,
    output logic [AW-1:0]       wr_addr,
    output cts_pkg::entry_t     wr_entry
);
    import cts_pkg::*;

    logic            pend_q;
    logic [AW-1:0]   pend_addr_q;
    entry_t          pend_entry_q;

    // Releases the pending write once the engine is idle.
    always_comb wr_en = pend_q && !engine_busy;
    always_comb wr_addr  = pend_addr_q;
    always_comb wr_entry = pend_entry_q;

    // Captures a new request or retires the pending one once written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q       <= 1'b0;
            pend_addr_q  <= '0;
            pend_entry_q <= '0;
        end else if (upd_en) begin
            pend_q             <= 1'b1;
            pend_addr_q        <= upd_addr;
            pend_entry_q.value <= upd_value;
            pend_entry_q.mask  <= upd_mask;
        end else if (wr_en) begin
            pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cts_match.sv
`timescale 1ns/1ps
// Module: cts_match
// Pure combinational compare of one captured identifier with one entry.
// Produces a full hit, a path-byte-only hit, and the retired indication.
// Assumes the path byte is the top VPI_W bits of the identifier.
module cts_match (
    input  logic [cts_pkg::ID_W-1:0] cell_id,
    input  cts_pkg::entry_t          entry,
    output logic                     full_hit,
    output logic                     vpi_hit,
    output logic                     retired
);
    import cts_pkg::*;

    logic [ID_W-1:0] diff_bits;

    for (genvar l = 0; l < ID_W; l++) begin : g_bit
        assign diff_bits[l] = (cell_id[l] ^ entry.value[l]) & ~entry.mask[l];
    end

    // Judges the entry: full compare, path-only compare, retired flag.
    always_comb begin
        retired  = &entry.mask;
        full_hit = ~|diff_bits && !retired;
        vpi_hit  = ~|diff_bits[ID_W-1 -: VPI_W]
                   && !(&entry.mask[ID_W-1 -: VPI_W]) && !retired;
    end
endmodule

// File: rtl/cts_engine.sv
`timescale 1ns/1ps
// Module: cts_engine
// Search controller: captures the identifier, steps the address counter
// one entry per cycle, and registers the result flags. Bypass is honoured
// only while idle. Assumes the table read is combinational.
module cts_engine #(
    parameter int  ENTRIES = 16,
    localparam int AW      = $clog2(ENTRIES),
    localparam logic [AW-1:0] LAST = AW'(ENTRIES - 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                header_ok,
    input  logic                id_avail,
    input  logic                bypass,
    input  logic                ext_tag,
    input  logic [cts_pkg::ID_W-1:0] cell_id,
    input  logic                full_hit,
    input  logic                vpi_hit,
    output logic [cts_pkg::ID_W-1:0] cell_q,
    output logic [AW-1:0]       addr_q,
    output logic                busy,
    output logic                conn_valid,
    output logic                conn_invalid,
    output logic                idle_cell,
    output logic [AW-1:0]       conn_id
);
    import cts_pkg::*;

    state_t state_q;
    logic   start;
    logic   accept;

    // Decodes the search start condition and entry acceptance.
    always_comb begin
        start  = (state_q == ST_IDLE) && header_ok && id_avail && !bypass;
        accept = full_hit || vpi_hit;
        busy   = (state_q == ST_SEARCH);
    end

    // Sequences the walk and registers the result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            cell_q       <= '0;
            addr_q       <= '0;
            conn_valid   <= 1'b0;
            conn_invalid <= 1'b0;
            idle_cell    <= 1'b0;
            conn_id      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q      <= ST_SEARCH;
                        cell_q       <= cell_id;
                        addr_q       <= '0;
                        conn_valid   <= 1'b0;
                        conn_invalid <= 1'b0;
                        idle_cell    <= 1'b0;
                        conn_id      <= '0;
                    end else if (bypass) begin
                        conn_valid   <= ext_tag;
                        conn_invalid <= 1'b0;
                        idle_cell    <= 1'b0;
                        conn_id      <= '0;
                    end
                end
                ST_SEARCH: begin
                    if (accept) begin
                        state_q    <= ST_IDLE;
                        conn_valid <= 1'b1;
                        conn_id    <= addr_q;
                        idle_cell  <= full_hit && (addr_q == '0);
                    end else if (addr_q == LAST) begin
                        state_q      <= ST_IDLE;
                        conn_invalid <= 1'b1;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/conn_table_search.sv
`timescale 1ns/1ps
// Module: conn_table_search
// Top of the masked sequential connection table search: table storage,
// deferred write path, per-entry comparator and search controller.
// Assumes ENTRIES is a power of two; identifier width comes from cts_pkg.
module conn_table_search #(
    parameter int                       ENTRIES    = 16,
    parameter logic [cts_pkg::ID_W-1:0] IDLE_VALUE = '0,
    localparam int                      AW         = $clog2(ENTRIES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        header_ok,
    input  logic                        id_avail,
    input  logic                        bypass,
    input  logic                        ext_tag,
    input  logic [cts_pkg::ID_W-1:0]    cell_id,
    input  logic                        upd_en,
    input  logic [AW-1:0]               upd_addr,
    input  logic [cts_pkg::ID_W-1:0]    upd_value,
    input  logic [cts_pkg::ID_W-1:0]    upd_mask,
    output logic                        busy,
    output logic                        conn_valid,
    output logic                        conn_invalid,
    output logic                        idle_cell,
    output logic [AW-1:0]               conn_id
);
    import cts_pkg::*;

    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    entry_t          wr_entry;
    entry_t          rd_entry;
    logic [AW-1:0]   addr_q;
    logic [ID_W-1:0] cell_q;
    logic            full_hit;
    logic            vpi_hit;
    logic            retired;

    cts_update #(.ENTRIES(ENTRIES)) u_update (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_en      (upd_en),
        .upd_addr    (upd_addr),
        .upd_value   (upd_value),
        .upd_mask    (upd_mask),
        .engine_busy (busy),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_entry    (wr_entry)
    );

    cts_table #(.ENTRIES(ENTRIES), .IDLE_VALUE(IDLE_VALUE)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_entry (wr_entry),
        .rd_addr  (addr_q),
        .rd_entry (rd_entry)
    );

    cts_match u_match (
        .cell_id  (cell_q),
        .entry    (rd_entry),
        .full_hit (full_hit),
        .vpi_hit  (vpi_hit),
        .retired  (retired)
    );

    cts_engine #(.ENTRIES(ENTRIES)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .header_ok    (header_ok),
        .id_avail     (id_avail),
        .bypass       (bypass),
        .ext_tag      (ext_tag),
        .cell_id      (cell_id),
        .full_hit     (full_hit),
        .vpi_hit      (vpi_hit),
        .cell_q       (cell_q),
        .addr_q       (addr_q),
        .busy         (busy),
        .conn_valid   (conn_valid),
        .conn_invalid (conn_invalid),
        .idle_cell    (idle_cell),
        .conn_id      (conn_id)
    );

    // Retired entries already fail both hits inside the comparator; this
    // immediate check ties that outcome to the separately driven flag.
    always_comb begin
        if (rst_n && retired) begin
            a_retired_rejected_r5 : assert (!full_hit && !vpi_hit);
        end
    end
endmodule

// File: rtl/cts_checker.sv
`timescale 1ns/1ps
// Module: cts_checker
// Temporal properties of the search block, bound onto conn_table_search.
// Assumes the same ENTRIES value as the block it observes.
module cts_checker #(
    parameter int  ENTRIES = 16,
    localparam int AW      = $clog2(ENTRIES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          header_ok,
    input logic          id_avail,
    input logic          bypass,
    input logic          ext_tag,
    input logic          busy,
    input logic          conn_valid,
    input logic          conn_invalid,
    input logic          idle_cell,
    input logic [AW-1:0] conn_id
);
    logic          go;
    logic [AW:0]   run_q;

    always_comb go = header_ok && id_avail && !bypass;

    // Counts busy cycles of the current walk.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    p_start_busy_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go) |=> busy);
    p_no_start_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go) |=> !busy);
    p_single_result_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        !(conn_valid && conn_invalid));
    p_idle_addr0_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        idle_cell |-> (conn_valid && conn_id == '0));
    p_bypass_tag_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bypass) |=> (conn_valid == $past(ext_tag) && !conn_invalid));
    p_end_result_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (conn_valid != conn_invalid));
    p_clear_busy_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!conn_valid && !conn_invalid && !idle_cell));
    p_walk_len_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < (AW+1)'(ENTRIES)));
    p_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go && !bypass) |=>
            ($stable(conn_valid) && $stable(conn_invalid) && $stable(idle_cell)));
endmodule

bind conn_table_search cts_checker #(.ENTRIES(ENTRIES)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .header_ok    (header_ok),
    .id_avail     (id_avail),
    .bypass       (bypass),
    .ext_tag      (ext_tag),
    .busy         (busy),
    .conn_valid   (conn_valid),
    .conn_invalid (conn_invalid),
    .idle_cell    (idle_cell),
    .conn_id      (conn_id)
);

// File: tb/conn_table_search_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module conn_table_search_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        header_ok = 1'b0;
    logic        id_avail = 1'b0;
    logic        bypass = 1'b0;
    logic        ext_tag = 1'b0;
    logic [23:0] cell_id = '0;
    logic        upd_en = 1'b0;
    logic [3:0]  upd_addr = '0;
    logic [23:0] upd_value = '0;
    logic [23:0] upd_mask = '0;
    logic        busy, conn_valid, conn_invalid, idle_cell;
    logic [3:0]  conn_id;

    int checks = 0;
    int errors = 0;

    conn_table_search dut_i (
        .clk(clk), .rst_n(rst_n), .header_ok(header_ok), .id_avail(id_avail),
        .bypass(bypass), .ext_tag(ext_tag), .cell_id(cell_id),
        .upd_en(upd_en), .upd_addr(upd_addr), .upd_value(upd_value),
        .upd_mask(upd_mask), .busy(busy), .conn_valid(conn_valid),
        .conn_invalid(conn_invalid), .idle_cell(idle_cell), .conn_id(conn_id)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input string what,
                         input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    // Offers one identifier, waits for the walk to end, returns busy length.
    task automatic run_search(input logic [23:0] id, output int cycles);
        @(negedge clk);
        header_ok = 1'b1; id_avail = 1'b1; cell_id = id;
        @(negedge clk);
        header_ok = 1'b0; id_avail = 1'b0;
        cycles = 0;
        while (busy && cycles < 40) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    task automatic expect_result(input string req, input int cycles,
                                 input int e_cycles, input int e_valid,
                                 input int e_invalid, input int e_id, input int e_idle);
        check(req, "busy_cycles", cycles, e_cycles);
        check(req, "conn_valid", int'(conn_valid), e_valid);
        check(req, "conn_invalid", int'(conn_invalid), e_invalid);
        check(req, "conn_id", int'(conn_id), e_id);
        check(req, "idle_cell", int'(idle_cell), e_idle);
    endtask

    task automatic write_entry(input logic [3:0] a, input logic [23:0] v,
                               input logic [23:0] m);
        @(negedge clk);
        upd_en = 1'b1; upd_addr = a; upd_value = v; upd_mask = m;
        @(negedge clk);
        upd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state;   // R11
        check("R11", "busy", int'(busy), 0);
        check("R11", "conn_valid", int'(conn_valid), 0);
        check("R11", "conn_invalid", int'(conn_invalid), 0);
        check("R11", "idle_cell", int'(idle_cell), 0);
    endtask

    task automatic t_idle_and_miss;   // R7, R6, R11
        int c;
        run_search(24'h000000, c);
        expect_result("R7", c, 1, 1, 0, 0, 1);
        run_search(24'h123456, c);
        expect_result("R6", c, 16, 0, 1, 0, 0);
    endtask

    task automatic t_exact_hit;   // R3
        int c;
        write_entry(4'd3, 24'h123456, 24'h000000);
        run_search(24'h123456, c);
        expect_result("R3", c, 4, 1, 0, 3, 0);
    endtask

    task automatic t_mask;   // R2
        int c;
        write_entry(4'd5, 24'h77AB00, 24'hFF00FF);
        run_search(24'h01AB99, c);
        expect_result("R2", c, 6, 1, 0, 5, 0);
        run_search(24'h01AC99, c);
        expect_result("R2", c, 16, 0, 1, 0, 0);
    endtask

    task automatic t_vpi_fallback;   // R4 with R3 ordering
        int c;
        write_entry(4'd7, 24'h3A0011, 24'h000000);
        write_entry(4'd9, 24'h3A0099, 24'h000000);
        run_search(24'h3A0099, c);
        expect_result("R4", c, 8, 1, 0, 7, 0);
    endtask

    task automatic t_retired;   // R5
        int c;
        write_entry(4'd3, 24'h123456, 24'hFFFFFF);
        run_search(24'h123456, c);
        expect_result("R5", c, 16, 0, 1, 0, 0);
    endtask

    task automatic t_start_gate;   // R1, R9 hold
        @(negedge clk);
        header_ok = 1'b0; id_avail = 1'b1; cell_id = 24'h000000;
        @(negedge clk);
        check("R1", "busy_no_header", int'(busy), 0);
        header_ok = 1'b1; id_avail = 1'b0;
        @(negedge clk);
        check("R1", "busy_no_avail", int'(busy), 0);
        header_ok = 1'b0;
        repeat (3) @(negedge clk);
        check("R9", "invalid_held", int'(conn_invalid), 1);
        check("R9", "valid_held", int'(conn_valid), 0);
    endtask

    task automatic t_bypass;   // R8
        @(negedge clk);
        bypass = 1'b1; ext_tag = 1'b1; header_ok = 1'b1; id_avail = 1'b1;
        @(negedge clk);
        check("R8", "busy", int'(busy), 0);
        check("R8", "conn_valid_tag1", int'(conn_valid), 1);
        check("R8", "conn_invalid", int'(conn_invalid), 0);
        ext_tag = 1'b0;
        @(negedge clk);
        check("R8", "conn_valid_tag0", int'(conn_valid), 0);
        bypass = 1'b0; header_ok = 1'b0; id_avail = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_deferred_write;   // R10
        int c;
        @(negedge clk);
        header_ok = 1'b1; id_avail = 1'b1; cell_id = 24'h5B0000;
        @(negedge clk);
        header_ok = 1'b0; id_avail = 1'b0;
        upd_en = 1'b1; upd_addr = 4'd2; upd_value = 24'h5B0000; upd_mask = '0;
        c = 1;
        @(negedge clk);
        upd_en = 1'b0;
        while (busy && c < 40) begin
            c++;
            @(negedge clk);
        end
        expect_result("R10", c, 16, 0, 1, 0, 0);
        @(negedge clk);
        run_search(24'h5B0000, c);
        expect_result("R10", c, 3, 1, 0, 2, 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_idle_and_miss();
        t_exact_hit();
        t_mask();
        t_vpi_fallback();
        t_retired();
        t_start_gate();
        t_bypass();
        t_deferred_write();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule